// File: doc/BRIEF.md
# Request-Triggered SPI Slave Result Responder

This block answers a host that wants one 16-bit measurement result. The host holds an active-low request line low for a minimum time. The block then raises a request toward an acquisition engine and waits for that engine's completion strobe, which carries the result word.

When the result arrives and the host has already released its request, the block signals data-ready by pulling an open-drain, active-low line low. It also starts driving the serial data output, with the most significant bit already presented. The host then supplies the serial clock. The block shifts the word out most significant bit first and releases data-ready after the sixteenth bit. Outside a transfer, the serial data output is tri-stated.

If the host is still holding the request low when the acquisition completes, no transfer takes place and the block enters setup mode instead. The serial clock and the request come from the host's clock domain. Both pass through synchronizers, and their edges are recovered in the system clock domain.

Top module: `spi_result_responder`

## Requirements
- R1: `acq_req_o` rises only after the synchronized request has been low for `REQ_MIN_CYCLES` consecutive system clocks. A shorter low pulse leaves `acq_req_o` at 0.
- R2: Once raised, `acq_req_o` stays high, whatever the request line does, until the cycle in which `acq_done_i` is 1. It is low from the next cycle on.
- R3: If the synchronized request is still low in the cycle `acq_done_i` is 1, `setup_o` goes to 1 while `drdy_pull_o` and `sdo_oe_o` stay 0. `setup_o` returns to 0 after the request line goes high again.
- R4: If the request has been released, `drdy_pull_o` and `sdo_oe_o` are 1 from the cycle after `acq_done_i`. At that point `sdo_o` already carries bit 15 of the captured word.
- R5: The word is sent as 16 bits, bit 15 first and bit 0 last, so the high byte leaves before the low byte.
- R6: With `cfg_sck_idle_high_i` = 0 (SCK idles low), `sdo_o` changes only after rising SCK edges. The first rising edge keeps bit 15. A host sampling on falling edges receives the word intact.
- R7: With `cfg_sck_idle_high_i` = 1 (SCK idles high), `sdo_o` changes only after falling SCK edges. The first falling edge keeps bit 15. A host sampling on rising edges receives the word intact.
- R8: After the sixteenth sampling edge, `drdy_pull_o` and `sdo_oe_o` return to 0 within a few system clocks.
- R9: SCK edges that occur while `drdy_pull_o` is 0 have no effect: the next transfer still starts at bit 15 and delivers all 16 bits.
- R10: After reset, `acq_req_o`, `drdy_pull_o`, `sdo_oe_o` and `setup_o` are 0. `drdy_pull_o` and `acq_req_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sck_idle_high_i | input | 1 | Clock idle level: 0 = idle low, 1 = idle high (static) |
| req_n_i | input | 1 | Host request, active low, asynchronous |
| acq_req_o | output | 1 | Request to the acquisition engine |
| acq_done_i | input | 1 | One-cycle completion strobe from the acquisition engine |
| acq_data_i | input | WORD_W | Result word, valid with `acq_done_i` |
| sck_i | input | 1 | Host serial clock, asynchronous |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; 0 means high impedance |
| drdy_pull_o | output | 1 | 1 pulls the open-drain data-ready line low |
| setup_o | output | 1 | Setup mode indicator |

## Verification
A control state that is stuck or entered wrongly shows at the ports within one system clock. It appears as `acq_req_o` or `drdy_pull_o` in the wrong state right after the completion strobe, or as `setup_o` rising when the request was already released. A wrong shift count or edge polarity only shows on the serial data. The host would collect a rotated or doubled bit, or data-ready would fall back too early or too late. The bench therefore compares every captured word and checks data-ready a few clocks after the sixteenth sampling edge.

// File: rtl/srr_pkg.sv
package srr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACQ   = 2'd1,
      ST_READY = 2'd2,
      ST_SETUP = 2'd3
   } srr_state_e;
endpackage

// File: rtl/srr_sync.sv
// Multi-stage synchronizer for an asynchronous single-bit input.
module srr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srr_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/srr_req_qual.sv
// Fires once when the request has been low for MIN_CYC consecutive clocks.
module srr_req_qual #(
   parameter int MIN_CYC = 3000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_low_i,
   output logic fire_o
);
   localparam int QW = $clog2(MIN_CYC + 1);
   localparam logic [QW-1:0] Q_SAT  = QW'(MIN_CYC);
   localparam logic [QW-1:0] Q_FIRE = QW'(MIN_CYC - 1);

   logic [QW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!req_low_i) cnt <= '0;
      else if (cnt != Q_SAT) cnt <= cnt + 1'b1;
   end

   assign fire_o = req_low_i && (cnt == Q_FIRE);
endmodule

// File: rtl/srr_shifter.sv
// Holds the result word, counts sampling edges, advances on launch edges.
module srr_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic              active_i,
   input  logic              launch_i,
   input  logic              sample_i,
   output logic              bit_o,
   output logic              done_o
);
   localparam int CW = $clog2(WORD_W);
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   logic [WORD_W-1:0] sh;
   logic [CW-1:0]     nsamp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         nsamp <= '0;
      end else if (load_i) begin
         sh    <= data_i;
         nsamp <= '0;
      end else if (active_i) begin
         if (sample_i) nsamp <= nsamp + 1'b1;
         // first launch edge keeps the MSB already on the line
         if (launch_i && (nsamp != '0)) sh <= {sh[WORD_W-2:0], 1'b0};
      end
   end

   assign bit_o  = sh[WORD_W-1];
   assign done_o = active_i && sample_i && (nsamp == LAST);
endmodule

// File: rtl/spi_result_responder.sv
module spi_result_responder
   import srr_pkg::*;
#(
   parameter int WORD_W         = 16,
   parameter int SYNC_STAGES    = 2,
   parameter int REQ_MIN_CYCLES = 3000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sck_idle_high_i,
   input  logic              req_n_i,
   output logic              acq_req_o,
   input  logic              acq_done_i,
   input  logic [WORD_W-1:0] acq_data_i,
   input  logic              sck_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic              drdy_pull_o,
   output logic              setup_o
);
   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("spi_result_responder: WORD_W must be at least 2");
      end
      if (REQ_MIN_CYCLES < 2) begin : g_bad_req
         $error("spi_result_responder: REQ_MIN_CYCLES must be at least 2");
      end
   endgenerate

   srr_state_e state, state_nx;
   logic req_n_s, req_low, req_fire;
   logic sck_s, sck_d, sck_rise, sck_fall, launch, sample;
   logic sh_bit, sh_done, load;

   srr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_n_i), .q(req_n_s));
   srr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));

   assign req_low = !req_n_s;

   srr_req_qual #(.MIN_CYC(REQ_MIN_CYCLES)) u_qual (
      .clk(clk), .rst_n(rst_n), .req_low_i(req_low), .fire_o(req_fire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign sck_rise = sck_s && !sck_d;
   assign sck_fall = !sck_s && sck_d;
   assign launch   = cfg_sck_idle_high_i ? sck_fall : sck_rise;
   assign sample   = cfg_sck_idle_high_i ? sck_rise : sck_fall;

   assign load = (state == ST_ACQ) && acq_done_i && !req_low;

   srr_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(load), .data_i(acq_data_i),
      .active_i(state == ST_READY), .launch_i(launch), .sample_i(sample),
      .bit_o(sh_bit), .done_o(sh_done));

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (req_fire) state_nx = ST_ACQ;
         ST_ACQ:   if (acq_done_i) state_nx = req_low ? ST_SETUP : ST_READY;
         ST_READY: if (sh_done) state_nx = ST_IDLE;
         ST_SETUP: if (!req_low) state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   assign acq_req_o   = (state == ST_ACQ);
   assign drdy_pull_o = (state == ST_READY);
   assign sdo_oe_o    = (state == ST_READY);
   assign sdo_o       = (state == ST_READY) ? sh_bit : 1'b0;
   assign setup_o     = (state == ST_SETUP);
endmodule

// File: rtl/srr_checker.sv
module srr_checker (
   input logic clk,
   input logic rst_n,
   input logic acq_req_o,
   input logic acq_done_i,
   input logic drdy_pull_o,
   input logic sdo_oe_o,
   input logic setup_o
);
   assert_acq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_req_o && !acq_done_i) |=> acq_req_o);

   assert_acq_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_req_o && acq_done_i) |=> !acq_req_o);

   assert_setup_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      setup_o |-> (!drdy_pull_o && !sdo_oe_o));

   assert_ready_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drdy_pull_o) |-> ($past(acq_done_i) && $past(acq_req_o)));

   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(drdy_pull_o && acq_req_o));
endmodule

bind spi_result_responder srr_checker u_srr_checker (
   .clk(clk), .rst_n(rst_n), .acq_req_o(acq_req_o), .acq_done_i(acq_done_i),
   .drdy_pull_o(drdy_pull_o), .sdo_oe_o(sdo_oe_o), .setup_o(setup_o));

// File: tb/tb_spi_result_responder.sv
`timescale 1ns/1ps
module tb_spi_result_responder;
   localparam int W    = 16;
   localparam int MINC = 40;
   localparam int HALF = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg = 1'b0;
   logic req_n = 1'b1;
   logic acq_done = 1'b0;
   logic [W-1:0] acq_data = '0;
   logic sck = 1'b0;
   logic acq_req, sdo, sdo_oe, drdy_pull, setup;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   spi_result_responder #(.WORD_W(W), .SYNC_STAGES(2), .REQ_MIN_CYCLES(MINC)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_sck_idle_high_i(cfg), .req_n_i(req_n),
      .acq_req_o(acq_req), .acq_done_i(acq_done), .acq_data_i(acq_data),
      .sck_i(sck), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .drdy_pull_o(drdy_pull),
      .setup_o(setup));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Qualify a request, then finish acquisition with req released
   task automatic start_and_complete(input logic [W-1:0] word, input bit toggle_sck);
      bit seen = 1'b0;
      req_n = 1'b0;
      tick(MINC + 10);
      for (int i = 0; i < 100 && !seen; i++) begin
         if (acq_req) seen = 1'b1; else tick(1);
      end
      check(seen, "R1 acquisition request after long low", int'(acq_req), 1);
      req_n = 1'b1;
      if (toggle_sck) begin
         // R9: stray clock edges while data-ready is not asserted
         for (int k = 0; k < 6; k++) begin sck = ~sck; tick(8); end
      end else tick(20);
      check(acq_req == 1'b1, "R2 request held until done", int'(acq_req), 1);
      acq_data = word;
      acq_done = 1'b1;
      tick(1);
      acq_done = 1'b0;
      check(drdy_pull && sdo_oe, "R4 data-ready after done", int'({drdy_pull, sdo_oe}), 3);
      check(sdo == word[W-1], "R4 MSB presented early", int'(sdo), int'(word[W-1]));
      check(acq_req == 1'b0, "R2 request dropped after done", int'(acq_req), 0);
   endtask

   // Host clocks out the word; samples on the sampling edge
   task automatic read_word(output logic [W-1:0] got, output bit stable);
      logic b;
      stable = 1'b1;
      got = '0;
      for (int i = 0; i < W; i++) begin
         if (i == 8) tick(12);
         sck = ~sck;               // launch edge
         tick(HALF);
         b = sdo;
         got = {got[W-2:0], b};
         sck = ~sck;               // sampling edge
         tick(5);
         if (i < W - 1 && sdo !== b) stable = 1'b0;
         tick(HALF - 5);
      end
   endtask

   task automatic t_reset();
      check(!acq_req && !drdy_pull && !sdo_oe && !setup, "R10 reset state",
            int'({acq_req, drdy_pull, sdo_oe, setup}), 0);
   endtask

   task automatic t_short_req();
      bit rose = 1'b0;
      req_n = 1'b0;
      tick(MINC - 10);
      req_n = 1'b1;
      for (int i = 0; i < 60; i++) begin
         if (acq_req) rose = 1'b1;
         tick(1);
      end
      check(!rose, "R1 short request ignored", int'(rose), 0);
   endtask

   task automatic t_transfer(input bit mode, input logic [W-1:0] word,
                             input bit stray, input string tag);
      logic [W-1:0] got;
      bit stable;
      cfg = mode;
      sck = mode;
      tick(10);
      start_and_complete(word, stray);
      if (stray) sck = mode;  // back to idle level
      read_word(got, stable);
      check(got == word, tag, int'(got), int'(word));
      check(stable, mode ? "R7 SDO steady after sampling edge" : "R6 SDO steady after sampling edge",
            int'(stable), 1);
      tick(8);
      check(!drdy_pull && !sdo_oe, "R8 release after 16th bit",
            int'({drdy_pull, sdo_oe}), 0);
   endtask

   task automatic t_setup();
      bit seen = 1'b0;
      cfg = 1'b0;
      sck = 1'b0;
      req_n = 1'b0;
      tick(MINC + 10);
      for (int i = 0; i < 100 && !seen; i++) begin
         if (acq_req) seen = 1'b1; else tick(1);
      end
      acq_data = 16'h1234;
      acq_done = 1'b1;
      tick(1);
      acq_done = 1'b0;
      check(setup && !drdy_pull && !sdo_oe, "R3 setup entered, no data-ready",
            int'({setup, drdy_pull, sdo_oe}), 4);
      tick(20);
      check(setup == 1'b1, "R3 setup held while request low", int'(setup), 1);
      req_n = 1'b1;
      tick(6);
      check(setup == 1'b0, "R3 setup left after release", int'(setup), 0);
   endtask

   initial begin
      for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(3);
      t_reset();
      t_short_req();
      t_transfer(1'b0, 16'hA53C, 1'b0, "R5 R6 word idle-low A53C");
      t_transfer(1'b0, 16'h8001, 1'b0, "R5 R6 word idle-low 8001");
      t_transfer(1'b1, 16'h5AC3, 1'b0, "R7 word idle-high 5AC3");
      t_transfer(1'b1, 16'h7FFE, 1'b0, "R7 word idle-high 7FFE");
      t_transfer(1'b0, 16'hF00F, 1'b1, "R9 stray edges ignored F00F");
      t_setup();
      t_transfer(1'b0, 16'h0C3A, 1'b0, "R3 R5 transfer after setup 0C3A");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule